// File: doc/BRIEF.md
# Group-Two Skip and Operate Unit

This block carries out the second family of operate microinstructions for a 12-bit accumulator machine. Each time the caller presents an instruction word with a valid strobe, the unit checks whether the word belongs to this family. If it does, the unit evaluates a conditional-skip test, can clear the accumulator, can OR a front-panel switch value into the accumulator, and can raise a halt request. One clock later it returns the new accumulator, a skip flag and a halt pulse, together with a done pulse.

The caller owns the program counter. It advances the counter by one extra word when the skip flag is set. The skip test always looks at the accumulator and link exactly as they were presented, so a clear or switch-OR in the same word never changes the skip decision. The control field is decoded in a fixed order: skip first, clear second, switch-OR and halt last. Words that are not in this family, or that set the reserved low bit, pass the accumulator through unchanged.

Top module: `g2_operate_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, done_o, skip_o, halt_o and acc_o are all zero.
- R2: A valid_i cycle produces done_o high in the next cycle. done_o is low after a cycle with valid_i low, and acc_o and skip_o then keep their previous values.
- R3: A word is in the family only when insn_i[11:8] is 4'b1111 and insn_i[0] is 0. Any other valid word yields acc_o equal to acc_i, skip_o low and halt_o low.
- R4: With the sense bit insn_i[3] at 0, skip_o is the OR of the enabled tests. insn_i[6] tests the accumulator MSB for 1 (negative), insn_i[5] tests the accumulator for zero, and insn_i[4] tests link_i for 1. With no test enabled, there is no skip.
- R5: With insn_i[3] at 1, skip_o is high only when none of the enabled tests from R4 holds. With no test enabled, skip_o is unconditionally high.
- R6: The skip decision uses acc_i as presented, not the value after the clear or switch-OR of the same word.
- R7: insn_i[7] set clears the accumulator before any switch-OR is applied.
- R8: insn_i[2] set makes acc_o the bitwise OR of the (possibly cleared) accumulator and switch_i, so clear together with switch-OR yields switch_i.
- R9: insn_i[1] set in a family word makes halt_o a single-cycle pulse that coincides with done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe, one cycle per word |
| insn_i | input | 12 | Instruction word |
| acc_i | input | DATA_W | Accumulator before the instruction |
| link_i | input | 1 | Link bit |
| switch_i | input | DATA_W | Front-panel switch value |
| done_o | output | 1 | Result valid, one cycle after valid_i |
| skip_o | output | 1 | Skip the next instruction |
| acc_o | output | DATA_W | Accumulator after the instruction |
| halt_o | output | 1 | Halt request pulse |

## Verification
The bench builds the unit with DATA_W set to 4. At that width, every accumulator value, both link values and all 128 settings of the seven control bits can be swept in full, each with two complementary switch patterns. This covers every pairing of sense polarity with the test selection, including the empty selection. It also reaches every case where a clear or switch-OR would alter the tested sign or zero state. A separate sweep of non-family words and reserved-bit words confirms the pass-through behaviour.

// File: rtl/g2op_pkg.sv
package g2op_pkg;

    localparam int INSN_W    = 12;
    localparam int OPC_HI    = 11;
    localparam int OPC_LO    = 8;
    localparam int BIT_CLR   = 7;
    localparam int BIT_MIN   = 6;
    localparam int BIT_ZERO  = 5;
    localparam int BIT_LINK  = 4;
    localparam int BIT_SENSE = 3;
    localparam int BIT_OSR   = 2;
    localparam int BIT_HLT   = 1;
    localparam int BIT_RSV   = 0;
    localparam int OPC_W     = OPC_HI - OPC_LO + 1;

    localparam logic [OPC_W-1:0] FAMILY_TAG = '1;

    typedef struct packed {
        logic is_fam;
        logic clr;
        logic t_min;
        logic t_zero;
        logic t_link;
        logic sense;
        logic osr;
        logic hlt;
    } g2_ctl_t;

endpackage

// File: rtl/g2op_decode.sv
module g2op_decode
    import g2op_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output g2_ctl_t           ctl_o
);

    logic fam;

    always_comb begin
        fam = (insn_i[OPC_HI:OPC_LO] == FAMILY_TAG) && !insn_i[BIT_RSV];
        ctl_o        = '0;
        ctl_o.is_fam = fam;
        if (fam) begin
            ctl_o.clr    = insn_i[BIT_CLR];
            ctl_o.t_min  = insn_i[BIT_MIN];
            ctl_o.t_zero = insn_i[BIT_ZERO];
            ctl_o.t_link = insn_i[BIT_LINK];
            ctl_o.sense  = insn_i[BIT_SENSE];
            ctl_o.osr    = insn_i[BIT_OSR];
            ctl_o.hlt    = insn_i[BIT_HLT];
        end
    end

endmodule

// File: rtl/g2op_cond.sv
module g2op_cond
    import g2op_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  g2_ctl_t           ctl_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              link_i,
    output logic              skip_o
);

    logic is_neg;
    logic is_zero;
    logic any_hit;

    always_comb begin
        is_neg  = acc_i[DATA_W-1];
        is_zero = (acc_i == '0);
        any_hit = (ctl_i.t_min  && is_neg)
                | (ctl_i.t_zero && is_zero)
                | (ctl_i.t_link && link_i);
        if (!ctl_i.is_fam) begin
            skip_o = 1'b0;
        end else if (ctl_i.sense) begin
            skip_o = !any_hit;
        end else begin
            skip_o = any_hit;
        end
    end

endmodule

// File: rtl/g2op_datapath.sv
module g2op_datapath
    import g2op_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  g2_ctl_t           ctl_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] switch_i,
    output logic [DATA_W-1:0] acc_o
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic kept;
        logic merged;
        always_comb begin
            kept     = acc_i[b] && !ctl_i.clr;
            merged   = ctl_i.osr && switch_i[b];
            acc_o[b] = kept || merged;
        end
    end

endmodule

// File: rtl/g2_operate_unit.sv
module g2_operate_unit
    import g2op_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              link_i,
    input  logic [DATA_W-1:0] switch_i,
    output logic              done_o,
    output logic              skip_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              halt_o
);

    typedef struct packed {
        logic              done;
        logic              skip;
        logic              halt;
        logic [DATA_W-1:0] acc;
    } state_t;

    g2_ctl_t           ctl;
    logic              skip_c;
    logic [DATA_W-1:0] acc_c;
    state_t            st_d;
    state_t            st_q;

    g2op_decode u_decode (
        .insn_i (insn_i),
        .ctl_o  (ctl)
    );

    g2op_cond #(.DATA_W(DATA_W)) u_cond (
        .ctl_i  (ctl),
        .acc_i  (acc_i),
        .link_i (link_i),
        .skip_o (skip_c)
    );

    g2op_datapath #(.DATA_W(DATA_W)) u_path (
        .ctl_i    (ctl),
        .acc_i    (acc_i),
        .switch_i (switch_i),
        .acc_o    (acc_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.halt = 1'b0;
        if (valid_i) begin
            st_d.done = 1'b1;
            st_d.skip = skip_c;
            st_d.acc  = acc_c;
            st_d.halt = ctl.hlt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign skip_o = st_q.skip;
    assign acc_o  = st_q.acc;
    assign halt_o = st_q.halt;

endmodule

// File: rtl/g2_operate_unit_chk.sv
module g2_operate_unit_chk
    import g2op_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [INSN_W-1:0] insn_i,
    input logic [DATA_W-1:0] acc_i,
    input logic              link_i,
    input logic [DATA_W-1:0] switch_i,
    input logic              done_o,
    input logic              skip_o,
    input logic [DATA_W-1:0] acc_o,
    input logic              halt_o
);

    logic fam_w;
    assign fam_w = (insn_i[OPC_HI:OPC_LO] == FAMILY_TAG) && !insn_i[BIT_RSV];

    a_r2_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> done_o);

    a_r2_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !done_o);

    a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(acc_o) && $stable(skip_o)));

    a_r9_halt_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |-> done_o);

    a_r3_noop_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !fam_w) |=> (acc_o == $past(acc_i) && !skip_o && !halt_o));

    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && fam_w && insn_i[BIT_CLR] && !insn_i[BIT_OSR]) |=> (acc_o == '0));

    a_r5_always_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && fam_w && insn_i[BIT_SENSE] && !insn_i[BIT_MIN]
         && !insn_i[BIT_ZERO] && !insn_i[BIT_LINK]) |=> skip_o);

    a_r8_switch_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && fam_w && insn_i[BIT_OSR]) |=> ((acc_o & $past(switch_i)) == $past(switch_i)));

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!done_o && !halt_o));

endmodule

bind g2_operate_unit g2_operate_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/g2_operate_unit_tb.sv
`timescale 1ns/1ps
module g2_operate_unit_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic [11:0]  insn = '0;
    logic [W-1:0] acc = '0;
    logic         link = 1'b0;
    logic [W-1:0] sw = '0;
    logic         done, skip, halt;
    logic [W-1:0] acc_out;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    g2_operate_unit #(.DATA_W(W)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .insn_i (insn),
        .acc_i (acc), .link_i (link), .switch_i (sw),
        .done_o (done), .skip_o (skip), .acc_o (acc_out), .halt_o (halt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one instruction: drive, sample registered result, then an idle cycle
    task automatic run_word(input logic [11:0] w, input logic [W-1:0] a,
                            input logic l, input logic [W-1:0] s,
                            output logic o_done, output logic o_skip,
                            output logic [W-1:0] o_acc, output logic o_halt);
        @(negedge clk);
        insn = w; acc = a; link = l; sw = s; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        o_done = done; o_skip = skip; o_acc = acc_out; o_halt = halt;
        acc = ~a; sw = ~s; link = ~l;
        @(negedge clk);
        check("R2", "idle done", int'(done), 0);
        check("R2", "idle acc hold", int'(acc_out), int'(o_acc));
        check("R2", "idle skip hold", int'(skip), int'(o_skip));
        check("R9", "idle halt", int'(halt), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic d, s, h;
        logic [W-1:0] a_o;
        repeat (3) @(negedge clk);
        check("R1", "reset done", int'(done), 0);
        check("R1", "reset skip", int'(skip), 0);
        check("R1", "reset halt", int'(halt), 0);
        check("R1", "reset acc", int'(acc_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset done", int'(done), 0);
        check("R1", "post-reset acc", int'(acc_out), 0);

        // full sweep of family words
        for (int c = 0; c < 128; c++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [6:0]   ctl;
                        logic [W-1:0] av, sv, e_acc;
                        logic         clr, tm, tz, tl, sen, osr, hl, hit, e_skip;
                        string        sreq, areq;
                        ctl = 7'(c);
                        av  = W'(a);
                        sv  = (p == 0) ? W'(5) : W'(10);
                        clr = ctl[6]; tm = ctl[5]; tz = ctl[4]; tl = ctl[3];
                        sen = ctl[2]; osr = ctl[1]; hl = ctl[0];
                        hit = (tm && av[W-1]) || (tz && (av == 0)) || (tl && l[0]);
                        e_skip = sen ? !hit : hit;
                        e_acc  = clr ? W'(0) : av;
                        if (osr) e_acc = e_acc | sv;
                        run_word({4'hF, ctl, 1'b0}, av, l[0], sv, d, s, a_o, h);
                        if ((clr || osr) && (tm || tz)) sreq = "R6";
                        else if (sen) sreq = "R5";
                        else sreq = "R4";
                        if (osr) areq = "R8";
                        else if (clr) areq = "R7";
                        else areq = "R3";
                        check("R2", "done", int'(d), 1);
                        check(sreq, "skip", int'(s), int'(e_skip));
                        check(areq, "acc", int'(a_o), int'(e_acc));
                        check("R9", "halt", int'(h), int'(hl));
                    end
                end
            end
        end

        // non-family and reserved-bit words
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 8; k++) begin
                logic [11:0]  w;
                logic [W-1:0] av;
                w  = {4'(op), 8'((k * 37) | 8'hFE)};
                if (op != 15) w[0] = k[0];
                else w[0] = 1'b1;
                av = W'(k * 3 + op);
                run_word(w, av, k[1], W'(15), d, s, a_o, h);
                check("R3", "noop done", int'(d), 1);
                check("R3", "noop acc", int'(a_o), int'(av));
                check("R3", "noop skip", int'(s), 0);
                check("R3", "noop halt", int'(h), 0);
            end
        end

        // back-to-back words: done stays high, halt pulses only once
        @(negedge clk);
        insn = {4'hF, 7'b0000011, 1'b0}; acc = W'(3); sw = W'(8); valid = 1'b1;
        @(negedge clk);
        insn = {4'hF, 7'b1000000, 1'b0};
        check("R9", "b2b halt first", int'(halt), 1);
        check("R8", "b2b acc first", int'(acc_out), 11);
        @(negedge clk);
        valid = 1'b0;
        check("R2", "b2b done second", int'(done), 1);
        check("R9", "b2b halt second", int'(halt), 0);
        check("R7", "b2b acc second", int'(acc_out), 0);
        @(negedge clk);
        check("R2", "b2b done idle", int'(done), 0);

        finish_run();
    end

endmodule